// File: doc/BRIEF.md
# Interrupt-Driven Transfer Channel Bank

This block holds eight small transfer channels. Each one answers a service request by moving a single data item instead of making the processor take an interrupt. A channel stores a source pointer, a destination pointer, a transfer count and three mode bits. When its trigger fires, the channel copies one byte or one 16-bit word from the source address to the destination address in one bus cycle. It then advances one of its two pointers and, unless it is in continuous mode, lowers its count by one.

When a counting channel has used up its count, the next trigger does not move any data. Instead it raises that channel's interrupt output, so the processor can refill the channel or finish the block transfer in software. Software programs and inspects every channel through a small register port.

The memory side is a read port and a write port used in the same cycle. The read data must come back combinationally, and the write takes place at the end of that cycle.

Top module: `evt_xfer_bank`

## Requirements
- R1: Register address bits [4:2] select the channel and bits [1:0] select the field: 0 is the source pointer (16 bits), 1 is the destination pointer (16 bits), 2 is the count (8 bits) and 3 is the mode (3 bits). Every field reads back the value last written, zero-extended.
- R2: A trigger sampled at a clock edge produces the service in the following cycle. For a move, the read strobe and the write strobe are both high in that one cycle. The read address is the channel's source pointer and the write address is its destination pointer.
- R3: Mode bit 0 set selects a word move: all 16 read bits are written and the byte indicator is low. With bit 0 clear, the move is a byte move: the byte indicator is high and the write data is the low read byte, zero-extended.
- R4: After a move, mode bit 1 clear advances the source pointer and bit 1 set advances the destination pointer. The step is 2 for a word move and 1 for a byte move. The other pointer keeps its value.
- R5: With mode bit 2 clear, each move lowers the count by one. With bit 2 set (continuous), moves leave the count unchanged.
- R6: A service on a non-continuous channel whose count is zero pulses that channel's interrupt output for one cycle. It makes no memory access and changes neither pointer nor the count.
- R7: When several channels are pending, the lowest-numbered one is served first, at one per cycle. The others stay pending until their turn.
- R8: A register write to a channel field in the same cycle that a service updates that field takes precedence over the service update.
- R9: Reset clears all channel registers and pending requests. No strobes or interrupts are active during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address: channel in [4:2], field in [1:0] |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Combinational readback of the addressed field |
| trig | input | 8 | Per-channel service request, one bit per channel |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 16 | Memory read byte address |
| memRdData | input | 16 | Combinational read data (byte at the address in [7:0]) |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 16 | Memory write byte address |
| memWrData | output | 16 | Memory write data |
| memByte | output | 1 | High for a single-byte access |
| irqOut | output | 8 | Per-channel interrupt pulse |

## Verification
Two kinds of event can land in the same cycle. One is several triggers arriving together: the bench raises three channels on one edge and expects three moves in ascending channel order on three consecutive cycles. The other is a software write and a hardware service hitting the same count register: the bench writes channel 7's count during the very cycle that channel 7 is serving. It then expects the move on the bus and the written count in readback, not the decremented one. Every expected bus transaction and interrupt is queued in advance and compared in order as it appears.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;
  localparam int NUM_CH     = 8;
  localparam int CHAN_IDX_W = $clog2(NUM_CH);
  localparam int MODE_W     = 3;
  localparam int MODE_WORD  = 0;
  localparam int MODE_DST   = 1;
  localparam int MODE_CONT  = 2;

  typedef struct packed {
    logic                  valid;
    logic                  move;
    logic                  irq;
    logic [CHAN_IDX_W-1:0] chan;
  } svc_t;
endpackage

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
  import evt_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] trig,
  input  logic [NUM_CH-1:0] cntZero,
  input  logic [NUM_CH-1:0] contMode,
  output svc_t              svc,
  output logic [NUM_CH-1:0] irqOut
);
  logic [NUM_CH-1:0]     pendingQ;
  logic [NUM_CH-1:0]     clrMask;
  logic [CHAN_IDX_W-1:0] selIdx;
  logic                  anyPending;

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendingQ[i]) selIdx = CHAN_IDX_W'(i);
    end
  end

  assign anyPending = |pendingQ;

  always_comb begin
    svc.valid = anyPending;
    svc.chan  = selIdx;
    svc.move  = anyPending && (contMode[selIdx] || !cntZero[selIdx]);
    svc.irq   = anyPending && !(contMode[selIdx] || !cntZero[selIdx]);
  end

  always_comb begin
    clrMask = '0;
    irqOut  = '0;
    if (anyPending) clrMask[selIdx] = 1'b1;
    if (svc.irq) irqOut[selIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= (pendingQ & ~clrMask) | trig;
  end

  a_r6_irq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  for (genvar g = 0; g < NUM_CH; g++) begin : gKeep
    a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rstN)
      (pendingQ[g] && svc.chan != CHAN_IDX_W'(g)) |=> pendingQ[g]);
  end
endmodule

// File: rtl/evt_xfer_dp.sv
module evt_xfer_dp
  import evt_xfer_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DW  = 16,
  parameter int RAW = CHAN_IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  svc_t              svc,
  input  logic              regWrEn,
  input  logic [RAW-1:0]    regAddr,
  input  logic [AW-1:0]     regWrData,
  output logic [AW-1:0]     regRdData,
  input  logic [DW-1:0]     memRdData,
  output logic              memRdEn,
  output logic [AW-1:0]     memRdAddr,
  output logic              memWrEn,
  output logic [AW-1:0]     memWrAddr,
  output logic [DW-1:0]     memWrData,
  output logic              memByte,
  output logic [NUM_CH-1:0] cntZero,
  output logic [NUM_CH-1:0] contMode
);
  localparam int HALF = DW / 2;

  logic [AW-1:0]     srcPtr [NUM_CH];
  logic [AW-1:0]     dstPtr [NUM_CH];
  logic [CW-1:0]     cnt    [NUM_CH];
  logic [MODE_W-1:0] mode   [NUM_CH];

  logic [CHAN_IDX_W-1:0] wrChan;
  logic [1:0]            wrField;
  assign wrChan  = regAddr[RAW-1:2];
  assign wrField = regAddr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic          hit;
    logic          wrHit;
    logic [AW-1:0] step;
    assign hit   = svc.move && svc.chan == CHAN_IDX_W'(g);
    assign wrHit = regWrEn && wrChan == CHAN_IDX_W'(g);
    assign step  = mode[g][MODE_WORD] ? AW'(2) : AW'(1);
    assign cntZero[g]  = (cnt[g] == '0);
    assign contMode[g] = mode[g][MODE_CONT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcPtr[g] <= '0;
        dstPtr[g] <= '0;
        cnt[g]    <= '0;
        mode[g]   <= '0;
      end else begin
        if (wrHit && wrField == 2'd0)             srcPtr[g] <= regWrData;
        else if (hit && !mode[g][MODE_DST])       srcPtr[g] <= srcPtr[g] + step;
        if (wrHit && wrField == 2'd1)             dstPtr[g] <= regWrData;
        else if (hit && mode[g][MODE_DST])        dstPtr[g] <= dstPtr[g] + step;
        if (wrHit && wrField == 2'd2)             cnt[g]    <= regWrData[CW-1:0];
        else if (hit && !mode[g][MODE_CONT])      cnt[g]    <= cnt[g] - 1'b1;
        if (wrHit && wrField == 2'd3)             mode[g]   <= regWrData[MODE_W-1:0];
      end
    end

    a_r4_other_ptr_kept: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !wrHit) |=>
        ($past(mode[g][MODE_DST]) ? $stable(srcPtr[g]) : $stable(dstPtr[g])));
    a_r5_cont_count_kept: assert property (@(posedge clk) disable iff (!rstN)
      (hit && mode[g][MODE_CONT] && !wrHit) |=> $stable(cnt[g]));
    a_r6_no_move_at_zero: assert property (@(posedge clk) disable iff (!rstN)
      (svc.valid && svc.chan == CHAN_IDX_W'(g) && cnt[g] == '0 && !mode[g][MODE_CONT])
        |-> !memRdEn && !memWrEn);
  end

  always_comb begin
    memRdEn   = svc.move;
    memWrEn   = svc.move;
    memRdAddr = srcPtr[svc.chan];
    memWrAddr = dstPtr[svc.chan];
    memByte   = !mode[svc.chan][MODE_WORD];
    memWrData = memByte ? {{(DW-HALF){1'b0}}, memRdData[HALF-1:0]} : memRdData;
  end

  always_comb begin
    unique case (wrField)
      2'd0:    regRdData = srcPtr[wrChan];
      2'd1:    regRdData = dstPtr[wrChan];
      2'd2:    regRdData = AW'(cnt[wrChan]);
      default: regRdData = AW'(mode[wrChan]);
    endcase
  end

  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !svc.valid |-> !memRdEn && !memWrEn);
endmodule

// File: rtl/evt_xfer_bank.sv
module evt_xfer_bank
  import evt_xfer_pkg::*;
#(
  parameter  int AW  = 16,
  parameter  int CW  = 8,
  parameter  int DW  = 16,
  localparam int RAW = CHAN_IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RAW-1:0]    regAddr,
  input  logic [AW-1:0]     regWrData,
  output logic [AW-1:0]     regRdData,
  input  logic [NUM_CH-1:0] trig,
  output logic              memRdEn,
  output logic [AW-1:0]     memRdAddr,
  input  logic [DW-1:0]     memRdData,
  output logic              memWrEn,
  output logic [AW-1:0]     memWrAddr,
  output logic [DW-1:0]     memWrData,
  output logic              memByte,
  output logic [NUM_CH-1:0] irqOut
);
  svc_t              svc;
  logic [NUM_CH-1:0] cntZero;
  logic [NUM_CH-1:0] contMode;

  evt_xfer_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .trig     (trig),
    .cntZero  (cntZero),
    .contMode (contMode),
    .svc      (svc),
    .irqOut   (irqOut)
  );

  evt_xfer_dp #(.AW(AW), .CW(CW), .DW(DW), .RAW(RAW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .svc       (svc),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memByte   (memByte),
    .cntZero   (cntZero),
    .contMode  (contMode)
  );
endmodule

// File: tb/evt_xfer_bank_test.sv
`timescale 1ns/1ps
module evt_xfer_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  trig = '0;
  logic        memRdEn, memWrEn, memByte;
  logic [15:0] memRdAddr, memWrAddr, memWrData, memRdData;
  logic [7:0]  irqOut;

  always #2.5 clk = ~clk;

  evt_xfer_bank uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trig(trig),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memByte(memByte), .irqOut(irqOut)
  );

  function automatic logic [7:0] fill(int a);
    return 8'((a & 255) * 7 + 3);
  endfunction
  function automatic logic [15:0] wordAt(int a);
    return {fill(a + 1), fill(a)};
  endfunction

  logic [7:0] mem [256];
  assign memRdData = {mem[memRdAddr[7:0] + 8'd1], mem[memRdAddr[7:0]]};
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= fill(i);
    end else if (memWrEn) begin
      mem[memWrAddr[7:0]] <= memWrData[7:0];
      if (!memByte) mem[memWrAddr[7:0] + 8'd1] <= memWrData[15:8];
    end
  end

  typedef struct {
    bit          isIrq;
    int          chan;
    logic [15:0] rdA, wrA, data;
    bit          byteMode;
    string       tag;
  } exp_t;
  exp_t q[$];

  int nChecks = 0;
  int nErrors = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (memRdEn || memWrEn || (irqOut != 0))) begin
      if (q.size() == 0) begin
        chk(0, "R2 unexpected bus or irq activity", {memRdAddr, 8'h0, irqOut}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.isIrq) begin
          chk(irqOut == 8'(1 << e.chan) && !memRdEn && !memWrEn,
              {e.tag, " irq"}, {7'd0, memRdEn, irqOut}, 32'(1 << e.chan));
        end else begin
          chk(memRdEn && memWrEn && irqOut == 0, {e.tag, " strobes"},
              {memRdEn, memWrEn, irqOut}, {2'b11, 8'h0});
          chk(memRdAddr == e.rdA && memWrAddr == e.wrA, {e.tag, " addresses"},
              {memRdAddr, memWrAddr}, {e.rdA, e.wrA});
          chk(memWrData == e.data && memByte == e.byteMode, {e.tag, " data"},
              {15'd0, memByte, memWrData}, {15'd0, e.byteMode, e.data});
        end
      end
    end
  end

  task automatic pushMove(int ch, int rdA, int wrA, bit isByte, string tag);
    exp_t e;
    e.isIrq = 0; e.chan = ch; e.rdA = 16'(rdA); e.wrA = 16'(wrA);
    e.byteMode = isByte;
    e.data = isByte ? {8'h00, fill(rdA)} : wordAt(rdA);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pushIrq(int ch, string tag);
    exp_t e;
    e.isIrq = 1; e.chan = ch; e.rdA = '0; e.wrA = '0; e.data = '0;
    e.byteMode = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic regWrite(int ch, int fld, int val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'((ch << 2) | fld); regWrData = 16'(val);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(int ch, int fld, int exp, string tag);
    @(negedge clk);
    regAddr = 5'((ch << 2) | fld);
    #1;
    chk(regRdData == 16'(exp), tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic setup(int ch, int src, int dst, int count, int md);
    regWrite(ch, 0, src);
    regWrite(ch, 1, dst);
    regWrite(ch, 2, count);
    regWrite(ch, 3, md);
  endtask

  task automatic fire(logic [7:0] mask);
    @(negedge clk);
    trig = mask;
    @(negedge clk);
    trig = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!memRdEn && !memWrEn && irqOut == 0, "R9 strobes in reset",
        {memRdEn, memWrEn, irqOut}, 0);
    rstN = 1'b1;
    regCheck(0, 0, 0, "R9 ch0 source after reset");
    regCheck(7, 3, 0, "R9 ch7 mode after reset");
    regCheck(4, 2, 0, "R9 ch4 count after reset");

    // R1: register readback
    setup(3, 16'h1234, 16'hBEEF, 8'hA5, 5);
    regCheck(3, 0, 16'h1234, "R1 source readback");
    regCheck(3, 1, 16'hBEEF, "R1 destination readback");
    regCheck(3, 2, 8'hA5, "R1 count readback");
    regCheck(3, 3, 5, "R1 mode readback");

    // R2 R3 R4 R5 R6: word, advance source, count 2
    setup(0, 16'h10, 16'h80, 2, 3'b001);
    pushMove(0, 16'h10, 16'h80, 0, "R2 ch0 first word");
    fire(8'h01);
    pushMove(0, 16'h12, 16'h80, 0, "R4 ch0 second word");
    fire(8'h01);
    pushIrq(0, "R6 ch0 count exhausted");
    fire(8'h01);
    regCheck(0, 0, 16'h14, "R4 ch0 source advanced by 2 per word");
    regCheck(0, 1, 16'h80, "R4 ch0 destination kept");
    regCheck(0, 2, 0, "R5 ch0 count after two moves");
    chk(mem[8'h80] == fill(16'h12) && mem[8'h81] == fill(16'h13),
        "R3 ch0 word landed", {mem[8'h81], mem[8'h80]}, wordAt(16'h12));

    // R3 R4: byte, advance destination
    setup(1, 16'h20, 16'h90, 1, 3'b010);
    pushMove(1, 16'h20, 16'h90, 1, "R3 ch1 byte");
    fire(8'h02);
    regCheck(1, 1, 16'h91, "R4 ch1 destination advanced by 1");
    regCheck(1, 0, 16'h20, "R4 ch1 source kept");
    chk(mem[8'h90] == fill(16'h20) && mem[8'h91] == fill(16'h91),
        "R3 ch1 single byte written", {mem[8'h91], mem[8'h90]},
        {fill(16'h91), fill(16'h20)});
    pushIrq(1, "R6 ch1 zero count gives irq");
    fire(8'h02);
    regCheck(1, 1, 16'h91, "R6 ch1 pointer untouched by irq");

    // R5: continuous mode
    setup(2, 16'h30, 16'hA0, 5, 3'b111);
    pushMove(2, 16'h30, 16'hA0, 0, "R5 ch2 cont 1");
    fire(8'h04);
    pushMove(2, 16'h30, 16'hA2, 0, "R5 ch2 cont 2");
    fire(8'h04);
    pushMove(2, 16'h30, 16'hA4, 0, "R5 ch2 cont 3");
    fire(8'h04);
    regCheck(2, 2, 5, "R5 ch2 count unchanged in continuous");
    regCheck(2, 1, 16'hA6, "R4 ch2 destination stepped");

    // R7: simultaneous triggers
    setup(4, 16'h40, 16'hC0, 1, 0);
    setup(5, 16'h42, 16'hC2, 1, 0);
    setup(6, 16'h44, 16'hC4, 1, 0);
    pushMove(4, 16'h40, 16'hC0, 1, "R7 ch4 first");
    pushMove(5, 16'h42, 16'hC2, 1, "R7 ch5 second");
    pushMove(6, 16'h44, 16'hC4, 1, "R7 ch6 third");
    fire(8'h70);
    regCheck(6, 2, 0, "R7 ch6 served eventually");

    // R8: register write collides with service
    setup(7, 16'h50, 16'hD0, 3, 3'b001);
    pushMove(7, 16'h50, 16'hD0, 0, "R8 ch7 move during write");
    @(negedge clk);
    trig = 8'h80;
    @(negedge clk);
    trig = '0;
    regWrEn = 1'b1; regAddr = 5'((7 << 2) | 2); regWrData = 16'd9;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    regCheck(7, 2, 9, "R8 written count wins over decrement");
    regCheck(7, 0, 16'h52, "R8 ch7 source still advanced");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all expected transfers seen", q.size(), 0);
    summary();
  end
endmodule